// File: doc/BRIEF.md
# Flash Block Program-Verify Loop Controller

This controller programs one 128-byte block of flash memory by writing, pulsing and reading back until every cell matches the requested data. Software first fills an internal 128-byte source buffer through a byte-wide load port while the controller is idle. A start strobe then raises the write-enable output, copies the source buffer into a working "retry" buffer and begins the loop. Each pass streams the 128 retry bytes to the flash write port, asks an external pulse sequencer for a programming pulse through a start/done handshake, and then enters verify mode. In verify mode every 16-bit word gets a dummy 0xFF write and a short wait before it is read back.

From each word read back the controller updates two buffers in the same cycle. The retry buffer marks the bits that still need programming. A "touch-up" buffer marks the bits that read programmed but were driven in the pass just applied. During the first N1 passes the touch-up buffer is written out and given a short pulse. The loop ends with success as soon as no bit needs more programming. It ends with failure once N1+N2 passes have been used. All wait lengths are counted in clock cycles and set by parameters.

Top module: `fpv_ctrl`

## Requirements
- R1: While idle (busy low), a cycle with `ld_en` high stores `ld_byte` at source index `ld_idx`. While busy, `ld_en` has no effect on the source buffer. If `start` and `ld_en` are high in the same idle cycle, `start` wins and the load is dropped.
- R2: After `start`, `swe` rises and a settling wait follows. Then every pass writes exactly 128 bytes, one per cycle, at addresses `{base_page, idx}` for idx 0 to 127 in rising order. The first pass writes the source data unchanged.
- R3: After each 128-byte burst, `pulse_start` is high for one cycle while `swe` is 1 and `pv` is 0. The controller then waits for `pulse_done`. The `pulse_kind` codes are 0 for a main pulse in pass n ≤ N1, 2 for a main pulse in pass n > N1, and 1 for a touch-up pulse.
- R4: In verify mode (`pv`=1), each of the 64 words goes through the same steps in rising order. First comes a dummy write of 0xFF to the even byte address, then a wait, then `rd_en` at that even address. `rd_data` is taken the cycle after `rd_en`. Bits [15:8] belong to the even byte and bits [7:0] to the odd byte.
- R5: For each bit, the new retry bit is 0 only when the source bit is 0 and the read bit is 1. Otherwise it is 1.
- R6: For each bit, the new touch-up bit is 0 only when the retry bit used in the pass just applied is 0 and the read bit is 0. Otherwise it is 1.
- R7: When the pass number n is at most N1, the controller drops `pv`, waits, writes the 128 touch-up bytes and issues a kind-1 pulse. No touch-up burst happens for n > N1.
- R8: If no bit of a verify sweep has source 0 and read 1, the controller clears `swe`, waits, and raises `done`, with `fail` low.
- R9: If bits still need programming after pass N1+N2, the controller clears `swe`, waits, and raises `fail`. Exactly N1+N2 main pulses are issued.
- R10: A bit that verified as programmed in one pass but reads erased in a later verify is written as 0 in the following pass.
- R11: After reset the controller is idle, with `swe`, `pv`, `wr_en`, `rd_en`, `pulse_start`, `busy`, `done` and `fail` all low.
- R12: `busy` is high from the cycle after `start` until the run finishes. `done` and `fail` are cleared at `start` and hold their final value until the next `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ld_en | input | 1 | Source buffer load strobe |
| ld_idx | input | 7 | Source buffer byte index |
| ld_byte | input | 8 | Source buffer byte value |
| start | input | 1 | Begin a programming run |
| base_page | input | AW-7 | Upper address bits of the 128-byte block |
| pulse_done | input | 1 | Pulse sequencer finished |
| rd_data | input | 16 | Word read from flash |
| swe | output | 1 | Flash write enable |
| pv | output | 1 | Verify mode |
| pulse_start | output | 1 | Request a programming pulse |
| pulse_kind | output | 2 | Pulse width class (0 short, 1 touch-up, 2 long) |
| wr_en | output | 1 | Flash byte write strobe |
| wr_addr | output | AW | Flash byte write address |
| wr_data | output | 8 | Flash byte write data |
| rd_en | output | 1 | Flash word read strobe |
| rd_addr | output | AW | Flash word read address (even) |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run ended with all bits verified |
| fail | output | 1 | Run ended with pass budget used up |

## Verification
The retry and touch-up buffers are both rewritten in the same capture cycle from one read word. The touch-up value must use the retry bit that was applied before this update, not the new one. The bench provokes this with cells that need one, two or three pulses, so that a single word holds bits that just programmed (retry 0, read 0) next to bits still erased (retry 0, read 1). Every touch-up and retry burst is compared byte for byte against values the bench derives from the read data it returned itself. A design that used the freshly updated retry bit would flip the touch-up bits of programmed cells and show up in the next burst.

// File: rtl/fpv_pkg.sv
package fpv_pkg;
    localparam int BLK_BYTES = 128;
    localparam int IDX_W     = 7;

    typedef enum logic [3:0] {
        S_IDLE, S_WAIT, S_WR, S_PULSE, S_PWAIT,
        S_VDUMMY, S_VREAD, S_VCAP, S_POST, S_CHECK, S_FINISH
    } fpv_state_e;

    localparam logic [1:0] PK_SHORT = 2'd0;
    localparam logic [1:0] PK_TOUCH = 2'd1;
    localparam logic [1:0] PK_LONG  = 2'd2;
endpackage

// File: rtl/fpv_bitcalc.sv
module fpv_bitcalc #(
    parameter int W = 16
) (
    input  logic [W-1:0] src_bits,
    input  logic [W-1:0] appl_bits,
    input  logic [W-1:0] rd_bits,
    output logic [W-1:0] retry_bits,
    output logic [W-1:0] touch_bits,
    output logic         incomplete
);
    logic [W-1:0] pending;

    for (genvar i = 0; i < W; i++) begin : g_bit
        // retry low only where source wants 0 and cell still reads 1
        assign pending[i]    = ~src_bits[i] & rd_bits[i];
        assign retry_bits[i] = ~pending[i];
        // touch-up low only where the applied bit was 0 and cell reads 0
        assign touch_bits[i] = appl_bits[i] | rd_bits[i];
    end

    assign incomplete = |pending;
endmodule

// File: rtl/fpv_timer.sv
module fpv_timer #(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] val,
    output logic          busy
);
    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_s;

    tmr_s tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (load) begin
            tmr_d.cnt = val;
        end else if (tmr_q.cnt != '0) begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign busy = (tmr_q.cnt != '0);

    // R4
    tmr_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !load |=> tmr_q.cnt == $past(tmr_q.cnt) - 1'b1);
endmodule

// File: rtl/fpv_ctrl.sv
module fpv_ctrl
    import fpv_pkg::*;
#(
    parameter int AW        = 16,
    parameter int N1        = 6,
    parameter int N2        = 994,
    parameter int TW        = 16,
    parameter int W_SWE_ON  = 50,
    parameter int W_PV_ON   = 4,
    parameter int W_DUMMY   = 2,
    parameter int W_PV_OFF  = 4,
    parameter int W_SWE_OFF = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ld_en,
    input  logic [6:0]    ld_idx,
    input  logic [7:0]    ld_byte,
    input  logic          start,
    input  logic [AW-8:0] base_page,
    input  logic          pulse_done,
    input  logic [15:0]   rd_data,
    output logic          swe,
    output logic          pv,
    output logic          pulse_start,
    output logic [1:0]    pulse_kind,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [7:0]    wr_data,
    output logic          rd_en,
    output logic [AW-1:0] rd_addr,
    output logic          busy,
    output logic          done,
    output logic          fail
);
    localparam int NW = $clog2(N1 + N2 + 1);
    localparam logic [NW-1:0] N1_L  = NW'(N1);
    localparam logic [NW-1:0] LIM_L = NW'(N1 + N2);

    typedef struct packed {
        fpv_state_e                      st;
        fpv_state_e                      ret;
        logic [IDX_W-1:0]                idx;
        logic [NW-1:0]                   n;
        logic                            m;
        logic                            swe;
        logic                            pv;
        logic                            phase;
        logic                            ok;
        logic                            done;
        logic                            fail;
        logic [AW-8:0]                   page;
        logic [BLK_BYTES-1:0][7:0]       src;
        logic [BLK_BYTES-1:0][7:0]       rep;
        logic [BLK_BYTES-1:0][7:0]       tch;
    } ctl_s;

    ctl_s ctl_d, ctl_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_busy;

    logic [IDX_W-1:0] ev_i, od_i;
    logic [15:0]      c_src, c_appl, c_rep, c_tch;
    logic             c_inc;

    assign ev_i   = {ctl_q.idx[IDX_W-1:1], 1'b0};
    assign od_i   = {ctl_q.idx[IDX_W-1:1], 1'b1};
    assign c_src  = {ctl_q.src[ev_i], ctl_q.src[od_i]};
    assign c_appl = {ctl_q.rep[ev_i], ctl_q.rep[od_i]};

    fpv_bitcalc #(.W(16)) u_calc (
        .src_bits   (c_src),
        .appl_bits  (c_appl),
        .rd_bits    (rd_data),
        .retry_bits (c_rep),
        .touch_bits (c_tch),
        .incomplete (c_inc)
    );

    fpv_timer #(.TW(TW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (tmr_load),
        .val   (tmr_val),
        .busy  (tmr_busy)
    );

    always_comb begin
        ctl_d       = ctl_q;
        tmr_load    = 1'b0;
        tmr_val     = '0;
        wr_en       = 1'b0;
        wr_addr     = {ctl_q.page, ctl_q.idx};
        wr_data     = ctl_q.phase ? ctl_q.tch[ctl_q.idx] : ctl_q.rep[ctl_q.idx];
        rd_en       = 1'b0;
        rd_addr     = {ctl_q.page, ev_i};
        pulse_start = 1'b0;
        if (ctl_q.phase)            pulse_kind = PK_TOUCH;
        else if (ctl_q.n <= N1_L)   pulse_kind = PK_SHORT;
        else                        pulse_kind = PK_LONG;

        case (ctl_q.st)
            S_IDLE: begin
                if (start) begin
                    ctl_d.st    = S_WAIT;
                    ctl_d.ret   = S_WR;
                    ctl_d.swe   = 1'b1;
                    ctl_d.rep   = ctl_q.src;
                    ctl_d.tch   = '1;
                    ctl_d.n     = NW'(1);
                    ctl_d.m     = 1'b0;
                    ctl_d.idx   = '0;
                    ctl_d.phase = 1'b0;
                    ctl_d.done  = 1'b0;
                    ctl_d.fail  = 1'b0;
                    ctl_d.page  = base_page;
                    tmr_load    = 1'b1;
                    tmr_val     = TW'(W_SWE_ON);
                end else if (ld_en) begin
                    ctl_d.src[ld_idx] = ld_byte;
                end
            end
            S_WAIT: begin
                if (!tmr_busy) ctl_d.st = ctl_q.ret;
            end
            S_WR: begin
                wr_en     = 1'b1;
                ctl_d.idx = ctl_q.idx + 7'd1;
                if (ctl_q.idx == 7'd127) ctl_d.st = S_PULSE;
            end
            S_PULSE: begin
                pulse_start = 1'b1;
                ctl_d.st    = S_PWAIT;
            end
            S_PWAIT: begin
                if (pulse_done) begin
                    if (!ctl_q.phase) begin
                        ctl_d.pv  = 1'b1;
                        ctl_d.m   = 1'b0;
                        ctl_d.idx = '0;
                        ctl_d.ret = S_VDUMMY;
                        ctl_d.st  = S_WAIT;
                        tmr_load  = 1'b1;
                        tmr_val   = TW'(W_PV_ON);
                    end else begin
                        ctl_d.st = S_CHECK;
                    end
                end
            end
            S_VDUMMY: begin
                wr_en     = 1'b1;
                wr_addr   = {ctl_q.page, ev_i};
                wr_data   = 8'hFF;
                ctl_d.ret = S_VREAD;
                ctl_d.st  = S_WAIT;
                tmr_load  = 1'b1;
                tmr_val   = TW'(W_DUMMY);
            end
            S_VREAD: begin
                rd_en    = 1'b1;
                ctl_d.st = S_VCAP;
            end
            S_VCAP: begin
                ctl_d.rep[ev_i] = c_rep[15:8];
                ctl_d.rep[od_i] = c_rep[7:0];
                ctl_d.tch[ev_i] = c_tch[15:8];
                ctl_d.tch[od_i] = c_tch[7:0];
                ctl_d.m         = ctl_q.m | c_inc;
                if (ctl_q.idx[IDX_W-1:1] == 6'h3F) begin
                    ctl_d.pv  = 1'b0;
                    ctl_d.idx = '0;
                    ctl_d.ret = S_POST;
                    ctl_d.st  = S_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(W_PV_OFF);
                end else begin
                    ctl_d.idx = ctl_q.idx + 7'd2;
                    ctl_d.st  = S_VDUMMY;
                end
            end
            S_POST: begin
                if (ctl_q.n <= N1_L) begin
                    ctl_d.phase = 1'b1;
                    ctl_d.idx   = '0;
                    ctl_d.st    = S_WR;
                end else begin
                    ctl_d.st = S_CHECK;
                end
            end
            S_CHECK: begin
                if (!ctl_q.m || ctl_q.n >= LIM_L) begin
                    ctl_d.swe = 1'b0;
                    ctl_d.ok  = !ctl_q.m;
                    ctl_d.ret = S_FINISH;
                    ctl_d.st  = S_WAIT;
                    tmr_load  = 1'b1;
                    tmr_val   = TW'(W_SWE_OFF);
                end else begin
                    ctl_d.n     = ctl_q.n + 1'b1;
                    ctl_d.phase = 1'b0;
                    ctl_d.idx   = '0;
                    ctl_d.st    = S_WR;
                end
            end
            S_FINISH: begin
                ctl_d.done = ctl_q.ok;
                ctl_d.fail = !ctl_q.ok;
                ctl_d.st   = S_IDLE;
            end
            default: ctl_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign swe  = ctl_q.swe;
    assign pv   = ctl_q.pv;
    assign busy = (ctl_q.st != S_IDLE);
    assign done = ctl_q.done;
    assign fail = ctl_q.fail;

    // R3
    pulse_env_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_start |-> swe && !pv && !wr_en && !rd_en);
    // R4
    dummy_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pv && wr_en |-> wr_data == 8'hFF && wr_addr[0] == 1'b0);
    // R4
    rd_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> pv && swe && rd_addr[0] == 1'b0);
    // R2
    wr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !pv && $past(wr_en) && !$past(pv) |->
            wr_addr[6:0] == $past(wr_addr[6:0]) + 7'd1);
    // R8
    done_swe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) || $rose(fail) |-> !swe && !pv && !busy);
    // R9
    n_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.n <= LIM_L);
    // R12
    start_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !busy |=> busy && !done && !fail);
    // R12
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fail));
endmodule

// File: tb/test_fpv_ctrl.sv
module test_fpv_ctrl;
    localparam int AW = 16;
    localparam int N1 = 2;
    localparam int N2 = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ld_en = 1'b0;
    logic [6:0]    ld_idx = '0;
    logic [7:0]    ld_byte = '0;
    logic          start = 1'b0;
    logic [AW-8:0] base_page = '0;
    logic          pulse_done = 1'b0;
    logic [15:0]   rd_data = '0;
    logic          swe, pv, pulse_start, wr_en, rd_en, busy, done, fail;
    logic [1:0]    pulse_kind;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [7:0]    wr_data;

    always #10 clk = ~clk;

    fpv_ctrl #(.AW(AW), .N1(N1), .N2(N2), .TW(8), .W_SWE_ON(4), .W_PV_ON(2),
               .W_DUMMY(1), .W_PV_OFF(2), .W_SWE_OFF(3)) i_fpv_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_idx(ld_idx), .ld_byte(ld_byte),
        .start(start), .base_page(base_page), .pulse_done(pulse_done), .rd_data(rd_data),
        .swe(swe), .pv(pv), .pulse_start(pulse_start), .pulse_kind(pulse_kind),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_en),
        .rd_addr(rd_addr), .busy(busy), .done(done), .fail(fail));

    int checks = 0;
    int failures = 0;

    task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // flash cell model
    int         req_c[1024];
    int         cnt_c[1024];
    logic [7:0] latch[128];
    logic [7:0] src_m[128];

    function automatic logic [7:0] cellb(int b);
        logic [7:0] r;
        for (int k = 0; k < 8; k++) r[k] = (cnt_c[b*8+k] >= req_c[b*8+k]) ? 1'b0 : 1'b1;
        return r;
    endfunction

    // scoreboard
    typedef struct packed {
        logic [1:0]         kind;
        logic [127:0][7:0]  data;
    } exp_t;
    exp_t exq[$];

    logic [7:0]        ref_x[128];
    logic [7:0]        ref_a[128];
    bit                ref_m;
    int                ref_n;
    int                exp_out;
    int                n_main, n_add, burst_cnt, rd_cnt, pd_cnt;
    int                disturb_bit = -1;
    logic [127:0][7:0] burst;

    function automatic exp_t mk(logic [1:0] k, bit use_a);
        exp_t e;
        e.kind = k;
        for (int b = 0; b < 128; b++) e.data[b] = use_a ? ref_a[b] : ref_x[b];
        return e;
    endfunction

    task automatic push_exp(logic [1:0] k, bit use_a);
        exq.push_back(mk(k, use_a));
    endtask

    task automatic sweep_end();
        if (ref_n <= N1) push_exp(2'd1, 1'b1);
        if (ref_m) begin
            if (ref_n >= N1 + N2) exp_out = 2;
            else begin
                ref_n++;
                push_exp((ref_n <= N1) ? 2'd0 : 2'd2, 1'b0);
            end
        end else begin
            exp_out = 1;
        end
    endtask

    // monitor: samples on falling edge, pops and compares
    always @(negedge clk) begin
        exp_t e;
        int   fd;
        int   a;
        logic [7:0] v, xo;
        bit   is_main;
        if (rst_n) begin
            if (pd_cnt > 0) begin
                pd_cnt--;
                pulse_done = (pd_cnt == 0);
            end else pulse_done = 1'b0;

            if (wr_en) begin
                if (pv) begin
                    chk(wr_data == 8'hFF, "R4", "dummy write data", 64'(wr_data), 64'hFF);
                    chk(wr_addr[6:0] == 7'(rd_cnt * 2), "R4", "dummy write address",
                        64'(wr_addr[6:0]), 64'(rd_cnt * 2));
                end else begin
                    chk(wr_addr[AW-1:7] == base_page, "R2", "write page",
                        64'(wr_addr[AW-1:7]), 64'(base_page));
                    chk(wr_addr[6:0] == 7'(burst_cnt), "R2", "write byte index",
                        64'(wr_addr[6:0]), 64'(burst_cnt));
                    burst[wr_addr[6:0]] = wr_data;
                    latch[wr_addr[6:0]] = wr_data;
                    burst_cnt++;
                end
            end

            if (pulse_start) begin
                is_main = (pulse_kind != 2'd1);
                if (is_main) n_main++; else n_add++;
                chk(burst_cnt == 128, "R2", "burst length", 64'(burst_cnt), 64'd128);
                if (exq.size() == 0) begin
                    chk(1'b0, "R3", "pulse with empty scoreboard", 64'(pulse_kind), 64'd0);
                end else begin
                    e = exq.pop_front();
                    chk(pulse_kind == e.kind, "R3 R7", "pulse kind", 64'(pulse_kind), 64'(e.kind));
                    fd = -1;
                    for (int b = 127; b >= 0; b--) if (burst[b] != e.data[b]) fd = b;
                    if (fd >= 0)
                        chk(1'b0, "R5 R6", $sformatf("burst byte %0d", fd),
                            64'(burst[fd]), 64'(e.data[fd]));
                    else
                        chk(1'b1, "R5 R6", "burst data", 64'd0, 64'd0);
                end
                if (disturb_bit >= 0 && is_main && n_main == 3)
                    chk(burst[disturb_bit/8][disturb_bit%8] == 1'b0, "R10",
                        "relapsed bit rewritten", 64'(burst[disturb_bit/8][disturb_bit%8]), 64'd0);
                if (disturb_bit >= 0 && is_main && n_main == 2) cnt_c[disturb_bit] = 0;
                for (int b = 0; b < 128; b++)
                    for (int k = 0; k < 8; k++)
                        if (latch[b][k] == 1'b0) cnt_c[b*8+k]++;
                burst_cnt = 0;
                pd_cnt = 3;
            end

            if (rd_en) begin
                a = int'(rd_addr[6:0]);
                chk(a == rd_cnt * 2, "R4", "read word order", 64'(a), 64'(rd_cnt * 2));
                if (rd_cnt == 0) ref_m = 1'b0;
                for (int j = 0; j < 2; j++) begin
                    v  = cellb(a + j);
                    xo = ref_x[a+j];
                    ref_x[a+j] = ~(~src_m[a+j] & v);
                    ref_a[a+j] = xo | v;
                    if ((~src_m[a+j] & v) != 8'h00) ref_m = 1'b1;
                end
                rd_data = {cellb(a), cellb(a + 1)};
                rd_cnt++;
                if (rd_cnt == 64) begin
                    rd_cnt = 0;
                    sweep_end();
                end
            end
        end
    end

    task automatic run_job(string name, logic [AW-8:0] page, int exp_main, int exp_add,
                           bit exp_ok, bit try_load);
        exp_t e0;
        for (int i = 0; i < 1024; i++) cnt_c[i] = 0;
        for (int i = 0; i < 128; i++) latch[i] = 8'hFF;
        for (int i = 0; i < 128; i++) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 7'(i); ld_byte = src_m[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        for (int i = 0; i < 128; i++) begin ref_x[i] = src_m[i]; ref_a[i] = 8'hFF; end
        ref_n = 1; exp_out = 0; n_main = 0; n_add = 0; burst_cnt = 0; rd_cnt = 0;
        exq.delete();
        push_exp(2'd0, 1'b0);
        e0 = exq[0];
        base_page = page;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done && !fail, "R12", {name, " busy after start"},
            64'({busy, done, fail}), 64'b100);
        if (try_load) begin
            @(negedge clk);
            ld_en = 1'b1; ld_idx = 7'd5; ld_byte = ~src_m[5];
            @(negedge clk);
            ld_en = 1'b0;
        end
        while (!(done || fail)) @(negedge clk);
        chk(done == exp_ok && fail == !exp_ok, exp_ok ? "R8" : "R9", {name, " outcome"},
            64'({done, fail}), 64'({exp_ok, !exp_ok}));
        chk(exp_out == (exp_ok ? 1 : 2), exp_ok ? "R8" : "R9", {name, " scoreboard outcome"},
            64'(exp_out), exp_ok ? 64'd1 : 64'd2);
        chk(n_main == exp_main, "R9", {name, " main pulses"}, 64'(n_main), 64'(exp_main));
        chk(n_add == exp_add, "R7", {name, " touch-up pulses"}, 64'(n_add), 64'(exp_add));
        chk(exq.size() == 0, "R3", {name, " leftover expected bursts"}, 64'(exq.size()), 64'd0);
        chk(!swe && !pv && !busy, "R8", {name, " idle outputs"}, 64'({swe, pv, busy}), 64'd0);
        if (exp_ok)
            for (int b = 0; b < 128; b++)
                if (cellb(b) != src_m[b])
                    chk(1'b0, "R8", $sformatf("%s cell %0d", name, b), 64'(cellb(b)), 64'(src_m[b]));
        if (e0.kind != 2'd0) chk(1'b0, "R3", "first kind", 64'(e0.kind), 64'd0);
        repeat (5) @(negedge clk);
        chk(done == exp_ok && fail == !exp_ok, "R12", {name, " flags held"},
            64'({done, fail}), 64'({exp_ok, !exp_ok}));
    endtask

    function automatic int find_zero_bit(int skip);
        int seen = 0;
        for (int j = 0; j < 1024; j++)
            if (src_m[j/8][j%8] == 1'b0) begin
                if (seen == skip) return j;
                seen++;
            end
        return 0;
    endfunction

    task automatic finish_bench();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R8 watchdog expired actual=hung expected=finished");
        finish_bench();
    end

    initial begin
        int sb, db;
        pd_cnt = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk({swe, pv, wr_en, rd_en, pulse_start, busy, done, fail} == 8'h00, "R11",
            "reset outputs", 64'({swe, pv, wr_en, rd_en, pulse_start, busy, done, fail}), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !swe, "R11", "idle after reset", 64'({busy, swe}), 64'd0);

        // A: every cell programs with one pulse (R1 R2 R5 R6 R7 R8)
        for (int i = 0; i < 128; i++) src_m[i] = (i % 16 == 15) ? 8'hFF : 8'((i * 37) ^ 8'h5A);
        for (int j = 0; j < 1024; j++) req_c[j] = 1;
        run_job("A", 9'h024, 1, 1, 1'b1, 1'b0);

        // B: slow cells, short then long pulses; load while busy must be dropped (R1 R3)
        for (int i = 0; i < 128; i++) src_m[i] = 8'(i * 91 + 3);
        src_m[5] = 8'hFF;
        for (int j = 0; j < 1024; j++) req_c[j] = 1 + (j % 3);
        run_job("B", 9'h069, 3, 2, 1'b1, 1'b1);

        // C: one stuck cell exhausts the budget (R9)
        for (int i = 0; i < 128; i++) src_m[i] = 8'((i * 37) ^ 8'h5A);
        for (int j = 0; j < 1024; j++) req_c[j] = 1;
        sb = find_zero_bit(3);
        req_c[sb] = 1000000;
        run_job("C", 9'h1FF, N1 + N2, N1, 1'b0, 1'b0);

        // D: a programmed bit relapses and is rewritten (R10)
        for (int j = 0; j < 1024; j++) req_c[j] = 1;
        sb = find_zero_bit(0);
        db = find_zero_bit(7);
        req_c[sb] = 2;
        disturb_bit = db;
        run_job("D", 9'h000, 3, 2, 1'b1, 1'b0);
        disturb_bit = -1;

        finish_bench();
    end
endmodule